// File: doc/BRIEF.md
# I2C Byte Engine with Clock-Stretch Timeout

This block is the bit-level engine of an I2C master. A controller hands it one command at a time: put a START condition on the bus, put a STOP condition on the bus, send one byte and sample the target's acknowledge, or receive one byte. A received byte is followed by an ACK, or by a NACK clock and then STOP when it is flagged as the last byte. Transactions of several bytes are built by the controller from these single commands.

The engine never drives a bus line high. Each line has only an output-enable to a pull-down, and a high level comes from releasing the line. Every time the engine releases SCL it waits for the line to read high, so a slow target can stretch the clock. If SCL stays low past a bounded window, the engine stops the command, releases both lines and latches a stretch error. A STOP is always followed by a long bus-free gap before the command completes. Quarter-bit time, stretch window and gap length are parameters counted in clock cycles.

Top module: `i2c_eng`

## Requirements
- R1: Both line enables (`scl_oe`, `sda_oe`, 1 = pull low) are 0 out of reset, and `busy`, `done` and `err_stretch` are 0. A logic 1 on either line is produced only by releasing it.
- R2: Command code 0 (START) leaves SDA released while SCL is released and high. It then pulls SDA low while SCL is still high, and finally pulls SCL low.
- R3: Command code 1 (STOP) pulls SCL and SDA low, releases SCL, waits for SCL high, then releases SDA while SCL is high. Both lines end released.
- R4: Command code 2 (WRITE) sends `cmd_wdata` as 8 bits, most significant first. SDA changes only while SCL is low, and a bit of value 1 is a released line.
- R5: On a WRITE, SDA is released for a ninth clock and sampled while SCL is high. `nack` is 1 if SDA was high on that clock and 0 if it was low.
- R6: Command code 3 (READ) samples SDA on 8 clocks while SCL is high, most significant bit first, and presents the byte on `rdata` when `done` pulses.
- R7: A READ with `cmd_last` = 0 pulls SDA low for the whole ninth clock (ACK) and releases SDA before `done`.
- R8: A READ with `cmd_last` = 1 leaves SDA released on the ninth clock (NACK) and then performs the STOP of R3 within the same command.
- R9: While a target holds SCL low after the engine has released it, the engine waits and delays its sampling. A data bit is sampled only while SCL is released and reads high.
- R10: If SCL stays low for `STRETCH_CYC` cycles after being released, the command ends with `done`. `err_stretch` rises and both lines are released. `err_stretch` holds until the next command is accepted, which clears it.
- R11: After the STOP's SDA release, `done` follows no sooner than `BUSFREE_CYC` cycles later.
- R12: `cmd_valid` is accepted only while `busy` is 0, and `busy` is 1 in the next cycle. `done` is a one-cycle pulse on the last busy cycle. A `cmd_valid` during `busy` has no effect.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cmd_valid | input | 1 | Command request, taken when idle |
| cmd_op | input | 2 | 0 START, 1 STOP, 2 WRITE, 3 READ |
| cmd_last | input | 1 | READ only: last byte, NACK then STOP |
| cmd_wdata | input | 8 | Byte to send on WRITE |
| busy | output | 1 | Command in progress |
| done | output | 1 | One-cycle completion pulse |
| rdata | output | 8 | Byte received by the last READ |
| nack | output | 1 | Target did not acknowledge the last WRITE |
| err_stretch | output | 1 | SCL held low past the stretch window |
| scl_in | input | 1 | Sensed SCL line level |
| sda_in | input | 1 | Sensed SDA line level |
| scl_oe | output | 1 | Pull SCL low when 1 |
| sda_oe | output | 1 | Pull SDA low when 1 |

## Verification
Bus-level results (START and STOP edges, the nine bit levels of each frame) can only be seen on the wires, so the bench's target model records each of them on the falling clock edge that follows the line change. Register results (`rdata`, `nack`, `err_stretch`, the final line enables) become valid in the cycle where `done` is high. The bench waits for that pulse and samples half a period after the edge that raised it, and never counts a fixed cycle number. The bus-free gap has a lower bound rather than an exact cycle count. Its check takes the difference between the cycle in which the STOP edge was seen and the cycle of `done`.

// File: rtl/i2c_eng_pkg.sv
package i2c_eng_pkg;
  localparam int BYTE_W  = 8;
  localparam int FRAME_W = BYTE_W + 1;

  typedef enum logic [1:0] {
    OP_START = 2'd0,
    OP_STOP  = 2'd1,
    OP_WRITE = 2'd2,
    OP_READ  = 2'd3
  } eng_op_e;

  typedef enum logic [3:0] {
    S_IDLE, S_STA_A, S_STA_R, S_STA_B, S_STA_C, S_STA_D,
    S_BIT_LO, S_BIT_R, S_BIT_HI, S_BIT_FALL,
    S_STO_A, S_STO_R, S_STO_B, S_STO_C, S_GAP, S_FIN
  } eng_st_e;

  function automatic int eng_max3(input int a, input int b, input int c);
    int m;
    m = (a > b) ? a : b;
    return (m > c) ? m : c;
  endfunction

  // Nine line levels of a byte frame: data then ninth-clock level.
  function automatic logic [FRAME_W-1:0] frame_bits(input eng_op_e op,
      input logic [BYTE_W-1:0] d, input logic last);
    if (op == OP_WRITE) return {d, 1'b1};
    return {{BYTE_W{1'b1}}, last};
  endfunction
endpackage

// File: rtl/i2c_eng_timer.sv
module i2c_eng_timer #(
  parameter int TW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [TW-1:0] val,
  output logic          zero
);
  logic [TW-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          cnt <= '0;
    else if (load)       cnt <= val;
    else if (cnt != '0)  cnt <= cnt - 1'b1;
  end

  assign zero = (cnt == '0);
endmodule

// File: rtl/i2c_eng_shift.sv
module i2c_eng_shift #(
  parameter int W = 9
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] load_val,
  input  logic         step,
  input  logic         sample_bit,
  output logic         tx_head,
  output logic [W-1:0] rx
);
  logic [W-1:0] tx;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tx <= '1;
      rx <= '0;
    end else if (load) begin
      tx <= load_val;
      rx <= '0;
    end else if (step) begin
      tx <= {tx[W-2:0], 1'b1};
      rx <= {rx[W-2:0], sample_bit};
    end
  end

  assign tx_head = tx[W-1];
endmodule

// File: rtl/i2c_eng.sv
module i2c_eng
  import i2c_eng_pkg::*;
#(
  parameter int QTR_CYC     = 32,
  parameter int STRETCH_CYC = 125000,
  parameter int BUSFREE_CYC = 7500
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_valid,
  input  logic [1:0]        cmd_op,
  input  logic              cmd_last,
  input  logic [BYTE_W-1:0] cmd_wdata,
  output logic              busy,
  output logic              done,
  output logic [BYTE_W-1:0] rdata,
  output logic              nack,
  output logic              err_stretch,
  input  logic              scl_in,
  input  logic              sda_in,
  output logic              scl_oe,
  output logic              sda_oe
);
  localparam int TW = $clog2(eng_max3(QTR_CYC, STRETCH_CYC, BUSFREE_CYC) + 1);
  localparam int CW = $clog2(FRAME_W + 1);
  localparam logic [TW-1:0] Q_LD = TW'(QTR_CYC - 1);
  localparam logic [TW-1:0] S_LD = TW'(STRETCH_CYC - 1);
  localparam logic [TW-1:0] G_LD = TW'(BUSFREE_CYC - 1);
  localparam logic [CW-1:0] LAST_BIT = CW'(FRAME_W - 1);

  eng_st_e             st, nxt;
  eng_op_e             op_q, in_op;
  logic                last_q, nack_q, err_q;
  logic                scl_rel, sda_rel, nscl, nsda;
  logic [CW-1:0]       bit_cnt;
  logic                bit_clr, bit_inc;
  logic                tmr_ld, tmr_zero;
  logic [TW-1:0]       tmr_val;
  logic                sh_ld, tx_head;
  logic [FRAME_W-1:0]  rx, ld_frame;

  // Named internal events, observed by the bound checker.
  logic acc_evt, smp_evt, tmo_evt, frame_end, cond_phase;

  assign in_op      = eng_op_e'(cmd_op);
  assign ld_frame   = frame_bits(in_op, cmd_wdata, cmd_last);
  assign acc_evt    = (st == S_IDLE) && cmd_valid;
  assign smp_evt    = (st == S_BIT_HI) && tmr_zero;
  assign frame_end  = (st == S_BIT_FALL) && tmr_zero && (bit_cnt == LAST_BIT);
  assign cond_phase = (st == S_STA_B) || (st == S_STA_C) ||
                      (st == S_STO_B) || (st == S_STO_C);

  i2c_eng_timer #(.TW(TW)) u_tmr (
    .clk(clk), .rst_n(rst_n), .load(tmr_ld), .val(tmr_val), .zero(tmr_zero)
  );

  i2c_eng_shift #(.W(FRAME_W)) u_sh (
    .clk(clk), .rst_n(rst_n), .load(sh_ld), .load_val(ld_frame),
    .step(smp_evt), .sample_bit(sda_in), .tx_head(tx_head), .rx(rx)
  );

  always_comb begin
    nxt = st;  tmr_ld = 1'b0;  tmr_val = Q_LD;  sh_ld = 1'b0;
    nscl = scl_rel;  nsda = sda_rel;  bit_clr = 1'b0;  bit_inc = 1'b0;
    tmo_evt = 1'b0;
    unique case (st)
      S_IDLE: if (cmd_valid) begin
        tmr_ld = 1'b1;  bit_clr = 1'b1;
        case (in_op)
          OP_START: begin nxt = S_STA_A; nsda = 1'b1; end
          OP_STOP:  begin nxt = S_STO_A; nscl = 1'b0; nsda = 1'b0; end
          default:  begin
            nxt = S_BIT_LO; sh_ld = 1'b1; nscl = 1'b0; nsda = ld_frame[FRAME_W-1];
          end
        endcase
      end
      S_STA_A:  if (tmr_zero) begin nxt = S_STA_R; nscl = 1'b1; tmr_ld = 1'b1; tmr_val = S_LD; end
      S_BIT_LO: if (tmr_zero) begin nxt = S_BIT_R; nscl = 1'b1; tmr_ld = 1'b1; tmr_val = S_LD; end
      S_STO_A:  if (tmr_zero) begin nxt = S_STO_R; nscl = 1'b1; tmr_ld = 1'b1; tmr_val = S_LD; end
      S_STA_R, S_BIT_R, S_STO_R: begin
        if (scl_in) begin
          tmr_ld = 1'b1;
          if (st == S_STA_R)      nxt = S_STA_B;
          else if (st == S_BIT_R) nxt = S_BIT_HI;
          else                    nxt = S_STO_B;
        end else if (tmr_zero) begin
          tmo_evt = 1'b1; nxt = S_FIN; nscl = 1'b1; nsda = 1'b1;
        end
      end
      S_STA_B:  if (tmr_zero) begin nxt = S_STA_C; nsda = 1'b0; tmr_ld = 1'b1; end
      S_STA_C:  if (tmr_zero) begin nxt = S_STA_D; nscl = 1'b0; tmr_ld = 1'b1; end
      S_STA_D:  if (tmr_zero) nxt = S_FIN;
      S_BIT_HI: if (tmr_zero) begin nxt = S_BIT_FALL; nscl = 1'b0; tmr_ld = 1'b1; end
      S_BIT_FALL: if (tmr_zero) begin
        tmr_ld = 1'b1;
        if (bit_cnt == LAST_BIT) begin
          if (op_q == OP_READ && last_q) begin nxt = S_STO_A; nsda = 1'b0; end
          else begin nxt = S_FIN; nsda = 1'b1; end
        end else begin
          bit_inc = 1'b1; nxt = S_BIT_LO; nsda = tx_head;
        end
      end
      S_STO_B:  if (tmr_zero) begin nxt = S_STO_C; nsda = 1'b1; tmr_ld = 1'b1; end
      S_STO_C:  if (tmr_zero) begin nxt = S_GAP; tmr_ld = 1'b1; tmr_val = G_LD; end
      S_GAP:    if (tmr_zero) nxt = S_FIN;
      S_FIN:    nxt = S_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= S_IDLE;  op_q <= OP_START;  last_q <= 1'b0;
      scl_rel <= 1'b1;  sda_rel <= 1'b1;  bit_cnt <= '0;
      nack_q <= 1'b0;  err_q <= 1'b0;
    end else begin
      st <= nxt;  scl_rel <= nscl;  sda_rel <= nsda;
      if (acc_evt) begin
        op_q <= in_op;  last_q <= cmd_last;  nack_q <= 1'b0;  err_q <= 1'b0;
      end
      if (bit_clr)      bit_cnt <= '0;
      else if (bit_inc) bit_cnt <= bit_cnt + 1'b1;
      if (tmo_evt) err_q <= 1'b1;
      if (frame_end && op_q == OP_WRITE) nack_q <= rx[0];
    end
  end

  assign busy        = (st != S_IDLE);
  assign done        = (st == S_FIN);
  assign rdata       = rx[FRAME_W-1:1];
  assign nack        = nack_q;
  assign err_stretch = err_q;
  assign scl_oe      = ~scl_rel;
  assign sda_oe      = ~sda_rel;
endmodule

// File: rtl/i2c_eng_chk.sv
module i2c_eng_chk (
  input logic clk,
  input logic rst_n,
  input logic cmd_valid,
  input logic busy,
  input logic done,
  input logic err_stretch,
  input logic scl_in,
  input logic scl_oe,
  input logic sda_oe,
  input logic smp_evt,
  input logic tmo_evt,
  input logic cond_phase
);
  // R12
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  // R12
  done_last_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> busy);
  // R12
  accept_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && cmd_valid) |=> busy);
  // R9
  sample_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
    smp_evt |-> (!scl_oe && scl_in));
  // R10
  timeout_err_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tmo_evt |=> (err_stretch && done && !scl_oe && !sda_oe));
  // R4
  sda_steady_hi_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!cond_phase && !err_stretch && !scl_oe && $past(!scl_oe)) |-> $stable(sda_oe));
endmodule

bind i2c_eng i2c_eng_chk u_chk (
  .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .busy(busy), .done(done),
  .err_stretch(err_stretch), .scl_in(scl_in), .scl_oe(scl_oe), .sda_oe(sda_oe),
  .smp_evt(smp_evt), .tmo_evt(tmo_evt), .cond_phase(cond_phase)
);

// File: tb/i2c_eng_test.sv
module i2c_eng_test;
  localparam int QTR = 3, STR = 60, BF = 25;
  localparam logic [1:0] C_START = 2'd0, C_STOP = 2'd1, C_WRITE = 2'd2, C_READ = 2'd3;

  logic clk = 1'b0, rst_n = 1'b0;
  logic cmd_valid = 1'b0, cmd_last = 1'b0;
  logic [1:0] cmd_op = 2'd0;
  logic [7:0] cmd_wdata = 8'd0, rdata;
  logic busy, done, nack, err_stretch, scl_oe, sda_oe;
  logic tgt_scl_low = 1'b0, tgt_sda_low = 1'b0;
  wire  scl_line = !scl_oe && !tgt_scl_low;
  wire  sda_line = !sda_oe && !tgt_sda_low;

  int total = 0, bad = 0, cyc = 0;
  int n_start = 0, n_stop = 0, stop_cyc = 0, done_cyc = 0;
  int stretch_cyc = 0, hold = 0, nrise = 0;
  logic tgt_rd = 1'b0, tgt_ack = 1'b1, quiet = 1'b0, bidx = 1'b0;
  logic [7:0] tgt_bytes [2];
  logic [8:0] fr = '0, last_fr = '0;
  logic prev_scl = 1'b1, prev_sda = 1'b1;

  always #4 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  i2c_eng #(.QTR_CYC(QTR), .STRETCH_CYC(STR), .BUSFREE_CYC(BF)) uut (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
    .cmd_last(cmd_last), .cmd_wdata(cmd_wdata), .busy(busy), .done(done),
    .rdata(rdata), .nack(nack), .err_stretch(err_stretch),
    .scl_in(scl_line), .sda_in(sda_line), .scl_oe(scl_oe), .sda_oe(sda_oe)
  );

  // Target model: watches the bus on falling clock edges.
  always @(negedge clk) begin
    logic sl, dl;
    sl = scl_line;  dl = sda_line;
    if (hold > 0) hold = hold - 1;
    if (prev_scl && sl && prev_sda && !dl) begin
      n_start = n_start + 1; nrise = 0; bidx = 1'b0; quiet = 1'b0;
    end
    if (prev_scl && sl && !prev_sda && dl) begin
      n_stop = n_stop + 1; stop_cyc = cyc;
    end
    if (!prev_scl && sl) begin
      fr = {fr[7:0], dl}; nrise = nrise + 1;
      if (nrise == 9) begin
        last_fr = fr;
        if (tgt_rd && dl) quiet = 1'b1;
      end
    end
    if (prev_scl && !sl) begin
      hold = stretch_cyc;
      if (nrise == 9) begin nrise = 0; if (tgt_rd) bidx = ~bidx; end
    end
    if (!sl) begin
      if (quiet)                     tgt_sda_low = 1'b0;
      else if (tgt_rd && nrise < 8)  tgt_sda_low = !tgt_bytes[bidx][7-nrise];
      else if (!tgt_rd && nrise == 8) tgt_sda_low = tgt_ack;
      else                           tgt_sda_low = 1'b0;
    end
    tgt_scl_low = (hold > 0);
    prev_scl = sl;  prev_sda = dl;
  end

  function automatic logic [8:0] exp_wr_frame(input logic [7:0] d, input logic ack);
    return {d, ~ack};
  endfunction

  function automatic logic [8:0] exp_rd_frame(input logic [7:0] d, input logic last);
    return {d, last};
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%0d exp=%0d", req, act, exp);
    end
  endtask

  task automatic issue(input logic [1:0] op, input logic [7:0] d, input logic lst);
    @(negedge clk);
    cmd_valid = 1'b1; cmd_op = op; cmd_wdata = d; cmd_last = lst;
    @(negedge clk);
    cmd_valid = 1'b0;
    while (!done) @(negedge clk);
    done_cyc = cyc;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    total++; bad++;
    $display("FAIL R12 watchdog act=%0d exp=%0d", 0, 1);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    int ns, np;
    logic [7:0] d, b0, b1;
    logic ack;
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk(!scl_oe && !sda_oe, "R1 lines released", {scl_oe, sda_oe}, 0);
    chk(!busy && !done && !err_stretch, "R1 status idle", {busy, done, err_stretch}, 0);

    // Writes: directed edge bytes then random, some with clock stretching
    for (int i = 0; i < 10; i++) begin
      d   = (i == 0) ? 8'h00 : (i == 1) ? 8'hFF : 8'($urandom);
      ack = (i < 2) ? 1'b1 : 1'($urandom);
      stretch_cyc = (i % 2 == 1) ? 4 + int'($urandom % 20) : 0;
      tgt_rd = 1'b0; tgt_ack = ack;
      ns = n_start;
      issue(C_START, 8'h00, 1'b0);
      chk(n_start == ns + 1, "R2 start seen", n_start, ns + 1);
      chk(scl_oe && sda_oe, "R2 ends with both low", {scl_oe, sda_oe}, 3);
      issue(C_WRITE, d, 1'b0);
      chk(last_fr == exp_wr_frame(d, ack), "R4 frame msb first", last_fr, exp_wr_frame(d, ack));
      chk(nack == ~ack, "R5 nack flag", nack, ~ack);
      if (stretch_cyc > 0) chk(!err_stretch, "R9 stretched write ok", err_stretch, 0);
      np = n_stop;
      issue(C_STOP, 8'h00, 1'b0);
      chk(n_stop == np + 1, "R3 stop seen", n_stop, np + 1);
      chk(!scl_oe && !sda_oe, "R3 lines released", {scl_oe, sda_oe}, 0);
      chk(done_cyc - stop_cyc >= BF, "R11 bus free gap", done_cyc - stop_cyc, BF);
    end

    // Two-byte reads
    for (int i = 0; i < 6; i++) begin
      b0 = (i == 0) ? 8'h80 : 8'($urandom);
      b1 = (i == 0) ? 8'h01 : 8'($urandom);
      stretch_cyc = (i % 2 == 0) ? 0 : 3 + int'($urandom % 15);
      tgt_bytes[0] = b0; tgt_bytes[1] = b1; tgt_rd = 1'b1;
      issue(C_START, 8'h00, 1'b0);
      issue(C_READ, 8'h00, 1'b0);
      chk(rdata == b0, "R6 first byte", rdata, b0);
      chk(last_fr == exp_rd_frame(b0, 1'b0), "R7 ack on ninth clock", last_fr, exp_rd_frame(b0, 1'b0));
      chk(!sda_oe, "R7 sda released after ack", sda_oe, 0);
      np = n_stop;
      issue(C_READ, 8'h00, 1'b1);
      chk(rdata == b1, "R6 last byte", rdata, b1);
      chk(last_fr == exp_rd_frame(b1, 1'b1), "R8 nack on ninth clock", last_fr, exp_rd_frame(b1, 1'b1));
      chk(n_stop == np + 1, "R8 stop follows", n_stop, np + 1);
      chk(!scl_oe && !sda_oe, "R8 lines released", {scl_oe, sda_oe}, 0);
      chk(done_cyc - stop_cyc >= BF, "R11 gap after read", done_cyc - stop_cyc, BF);
    end
    tgt_rd = 1'b0; stretch_cyc = 0;

    // R12 command while busy is ignored
    tgt_ack = 1'b1;
    issue(C_START, 8'h00, 1'b0);
    np = n_stop;
    @(negedge clk);
    cmd_valid = 1'b1; cmd_op = C_WRITE; cmd_wdata = 8'h3C;
    @(negedge clk);
    cmd_valid = 1'b0;
    repeat (6) @(negedge clk);
    cmd_valid = 1'b1; cmd_op = C_STOP; cmd_wdata = 8'hC3;
    @(negedge clk);
    cmd_valid = 1'b0;
    while (!done) @(negedge clk);
    chk(last_fr == exp_wr_frame(8'h3C, 1'b1), "R12 busy ignores cmd", last_fr, exp_wr_frame(8'h3C, 1'b1));
    chk(n_stop == np, "R12 no stray stop", n_stop, np);
    @(negedge clk);
    chk(!busy && !done, "R12 done one cycle", {busy, done}, 0);
    issue(C_STOP, 8'h00, 1'b0);

    // R10 stretch timeout
    stretch_cyc = 200;
    issue(C_START, 8'h00, 1'b0);
    chk(!err_stretch, "R10 no error before", err_stretch, 0);
    issue(C_WRITE, 8'h5A, 1'b0);
    chk(err_stretch, "R10 timeout flagged", err_stretch, 1);
    chk(!scl_oe && !sda_oe, "R10 lines released", {scl_oe, sda_oe}, 0);
    repeat (260) @(negedge clk);
    stretch_cyc = 0;
    chk(err_stretch, "R10 error held", err_stretch, 1);
    issue(C_STOP, 8'h00, 1'b0);
    chk(!err_stretch, "R10 cleared by next cmd", err_stretch, 0);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule